// File: doc/BRIEF.md
# Gated Table-Base Register Bank

This block holds eight 64-bit configuration words. Each word tells an interrupt translation unit where one of its in-memory tables starts. Software reaches the words through a simple memory-mapped port that carries a single access per cycle. An access is either 32 or 64 bits wide, and is either a read or a write.

Each word mixes two kinds of field:
- **Fixed fields, set by parameters.** A table-kind code and an entry-size code. Software cannot change them.
- **Writable bits.** The address and attribute bits, which software programs.

A word whose kind code is zero is treated as an empty slot. It always reads as zero and discards every write, so it can never hold a nonzero base.

A single control word carries the unit's run bit. While the run bit is set, the table words are frozen. Software must clear the run bit, reprogram the words, and then set the run bit again.

Top module: `tbl_base_bank`

## Requirements
- R1: After reset the run bit is 0 and every writable bit of every entry is 0. An implemented entry then reads back only its fixed fields. With defaults: entry 0 reads 0x0107000000000000 and entry 1 reads 0x040F000000000000.
- R2: The control word sits at byte offset 0x000. Entry n sits at byte offset 0x100 + 8*n, for n = 0..7. Accesses anywhere else read zero and change nothing. For example, 0x140 is outside the window.
- R3: The kind code in bits [58:56] and the entry-size code in bits [52:48] are read-only. A write never changes them.
- R4: An entry whose kind code is 0 reads as zero at every width and half, and ignores every write. With defaults, entries 2 to 7 are such entries.
- R5: While the run bit is 1, writes to any entry leave it unchanged.
- R6: A 32-bit write uses byte-offset bit 2 to pick a half: 1 selects bits [63:32], 0 selects bits [31:0]. The data comes from wdata[31:0]. The other half keeps its value.
- R7: A 64-bit write to an implemented entry, with the run bit 0, replaces all writable bits at once.
- R8: A 64-bit read returns the whole word, and offset bits [2:0] are ignored. A 32-bit read returns the half picked by offset bit 2 in rdata[31:0], with rdata[63:32] = 0. When there is no read, rdata is 0.
- R9: The run bit is bit 0 of the control word, and its other bits read 0. A 64-bit write, or a 32-bit write with offset bit 2 = 0, loads it from wdata[0], and the new value governs accesses from the next cycle on. A 32-bit write to offset 0x004 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_addr | input | 12 | Byte offset of the access |
| acc_wdata | input | 64 | Write data; a 32-bit write uses bits [31:0] |
| acc_rdata | output | 64 | Read data, combinational, for the current access |

## Verification
The bench targets four ways this design can go wrong:

- **Empty slots.** A design that let writes into an empty slot would read back a nonzero value at 0x110 or 0x138.
- **Upper-half writes.** The upper-half 32-bit write must move its data into bits [63:32] and keep the fixed codes. A mistake here shows up as a corrupted lower half or a lost kind code.
- **Run bit.** The bench writes an entry in the first cycle after setting the run bit, and later after clearing it. A design that latched the gate one cycle late, or ignored the gate, would change that entry.
- **Boundaries.** The bench probes the first offset past the window, a write to offset 0x004 of the control word, and a mid-run reset. Address decodes that are off by one, or state that a reset did not clear, show up in these probes.

// File: rtl/tbl_base_bank.sv
`timescale 1ns/1ps
module tbl_base_bank #(
  parameter int ADDR_W   = 12,
  parameter int NUM_ENT  = 8,
  parameter int CTRL_OFS = 'h000,
  parameter int BANK_OFS = 'h100,
  parameter logic [NUM_ENT*3-1:0] KINDS = 24'h000021,
  parameter logic [NUM_ENT*5-1:0] SIZES = 40'h00000001E7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_wide,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [63:0]       acc_wdata,
  output logic [63:0]       acc_rdata
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [63:0] RO_MASK = 64'h071F_0000_0000_0000;
  localparam logic [ADDR_W:0] BASE_A = (ADDR_W+1)'(BANK_OFS);
  localparam logic [ADDR_W:0] END_A  = (ADDR_W+1)'(BANK_OFS + 8*NUM_ENT);
  localparam logic [ADDR_W-4:0] CTRL_W = (ADDR_W-3)'(CTRL_OFS >> 3);

  logic              en_q;
  logic [63:0]       wbits_q [NUM_ENT];
  logic [63:0]       ent_val [NUM_ENT];
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic              bank_hit, ctrl_hit, wr_acc, rd_acc;
  logic [63:0]       wmask, wdata_al, full_val;

  assign off      = acc_addr - ADDR_W'(BANK_OFS);
  assign idx      = off[IDX_W+2:3];
  assign bank_hit = ({1'b0, acc_addr} >= BASE_A) && ({1'b0, acc_addr} < END_A);
  assign ctrl_hit = acc_addr[ADDR_W-1:3] == CTRL_W;
  assign wr_acc   = acc_valid && acc_write;
  assign rd_acc   = acc_valid && !acc_write;

  wire unused_addr = ^{acc_addr[1:0], off};

  assign wdata_al = acc_wide     ? acc_wdata :
                    acc_addr[2]  ? {acc_wdata[31:0], 32'h0} : {32'h0, acc_wdata[31:0]};
  assign wmask    = ~RO_MASK & (acc_wide    ? {64{1'b1}} :
                                acc_addr[2] ? {{32{1'b1}}, 32'h0} : {32'h0, {32{1'b1}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= 1'b0;
    else if (wr_acc && ctrl_hit && (acc_wide || !acc_addr[2]))
      en_q <= acc_wdata[0];
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ENT; gi++) begin : g_ent
      localparam logic [2:0] KIND = KINDS[gi*3 +: 3];
      localparam logic [4:0] ESZ  = SIZES[gi*5 +: 5];
      localparam bit IMPL = (KIND != 3'd0);
      localparam logic [63:0] RO_VAL = IMPL ? ({5'd0, KIND, 3'd0, ESZ, 48'd0}) : 64'd0;
      logic hit;

      assign hit = wr_acc && bank_hit && (idx == IDX_W'(gi)) && !en_q && IMPL;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          wbits_q[gi] <= 64'd0;
        else if (hit)
          wbits_q[gi] <= (wbits_q[gi] & ~wmask) | (wdata_al & wmask);
      end

      assign ent_val[gi] = IMPL ? ((wbits_q[gi] & ~RO_MASK) | RO_VAL) : 64'd0;

      AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(wbits_q[gi])); // R5

      AST_UPPER_KEEPS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bank_hit && idx == IDX_W'(gi) && !acc_wide && acc_addr[2])
        |=> $stable(wbits_q[gi][31:0])); // R6

      if (!IMPL) begin : g_unimp
        AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
          wbits_q[gi] == 64'd0); // R4
      end
    end
  endgenerate

  always_comb begin
    full_val = 64'd0;
    if (bank_hit)      full_val = ent_val[idx];
    else if (ctrl_hit) full_val = {63'd0, en_q};
  end

  assign acc_rdata = !rd_acc   ? 64'd0 :
                     acc_wide  ? full_val :
                     {32'h0, (acc_addr[2] ? full_val[63:32] : full_val[31:0])};

  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !bank_hit && !ctrl_hit) |-> acc_rdata == 64'd0); // R2

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_wide) |-> acc_rdata[63:32] == 32'd0); // R8

  AST_RUN_BIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ctrl_hit && (acc_wide || !acc_addr[2])) |=> en_q == $past(acc_wdata[0])); // R9
endmodule

// File: tb/sim_tbl_base_bank.sv
`timescale 1ns/1ps
module sim_tbl_base_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tbl_base_bank u0 (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata));

  localparam int NV = 31;
  localparam logic [145:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b1, 12'h100, 64'h0, 64'h0107000000000000},          // R1 entry0
    {4'd1, 1'b0, 1'b1, 12'h108, 64'h0, 64'h040F000000000000},          // R1 entry1
    {4'd4, 1'b0, 1'b1, 12'h110, 64'h0, 64'h0},                         // R4
    {4'd1, 1'b0, 1'b1, 12'h000, 64'h0, 64'h0},                         // R1 ctrl
    {4'd7, 1'b1, 1'b1, 12'h100, 64'hFFFFFFFFFFFFFFFF, 64'h0},
    {4'd3, 1'b0, 1'b1, 12'h100, 64'h0, 64'hF9E7FFFFFFFFFFFF},          // R3 R7
    {4'd6, 1'b1, 1'b0, 12'h100, 64'h12345678, 64'h0},
    {4'd6, 1'b0, 1'b1, 12'h100, 64'h0, 64'hF9E7FFFF12345678},          // R6 lower
    {4'd6, 1'b1, 1'b0, 12'h104, 64'hFFFFFFFF00000000, 64'h0},
    {4'd6, 1'b0, 1'b1, 12'h100, 64'h0, 64'h0107000012345678},          // R6 upper
    {4'd8, 1'b0, 1'b0, 12'h104, 64'h0, 64'h0000000001070000},          // R8 hi
    {4'd8, 1'b0, 1'b0, 12'h100, 64'h0, 64'h0000000012345678},          // R8 lo
    {4'd4, 1'b1, 1'b1, 12'h110, 64'hFFFFFFFFFFFFFFFF, 64'h0},
    {4'd4, 1'b0, 1'b1, 12'h110, 64'h0, 64'h0},                         // R4
    {4'd4, 1'b1, 1'b0, 12'h13C, 64'hFFFFFFFF, 64'h0},
    {4'd4, 1'b0, 1'b1, 12'h138, 64'h0, 64'h0},                         // R4 entry7
    {4'd4, 1'b0, 1'b0, 12'h13C, 64'h0, 64'h0},                         // R4 narrow
    {4'd2, 1'b1, 1'b1, 12'h140, 64'hFFFFFFFFFFFFFFFF, 64'h0},
    {4'd2, 1'b0, 1'b1, 12'h140, 64'h0, 64'h0},                         // R2
    {4'd7, 1'b1, 1'b1, 12'h108, 64'h000000000000A000, 64'h0},
    {4'd7, 1'b0, 1'b1, 12'h108, 64'h0, 64'h040F00000000A000},          // R7
    {4'd9, 1'b1, 1'b0, 12'h000, 64'h1, 64'h0},
    {4'd5, 1'b1, 1'b1, 12'h100, 64'h0, 64'h0},
    {4'd5, 1'b0, 1'b1, 12'h100, 64'h0, 64'h0107000012345678},          // R5
    {4'd9, 1'b0, 1'b0, 12'h000, 64'h0, 64'h1},                         // R9
    {4'd9, 1'b1, 1'b0, 12'h004, 64'h0, 64'h0},
    {4'd9, 1'b0, 1'b1, 12'h000, 64'h0, 64'h1},                         // R9 hi write
    {4'd9, 1'b1, 1'b0, 12'h000, 64'h0, 64'h0},
    {4'd9, 1'b1, 1'b1, 12'h108, 64'h0, 64'h0},
    {4'd9, 1'b0, 1'b1, 12'h108, 64'h0, 64'h040F000000000000},          // R9 unlocked
    {4'd2, 1'b0, 1'b0, 12'h0F8, 64'h0, 64'h0}                          // R2 below
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic wide, input logic [11:0] a,
                        input logic [63:0] d, input string req, input logic [63:0] exp);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_wide = wide; acc_addr = a; acc_wdata = d;
    #2;
    if (!wr) check(req, acc_rdata, exp);
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][141], VEC[i][140], VEC[i][139:128], VEC[i][127:64],
             $sformatf("R%0d vec%0d", VEC[i][145:142], i), VEC[i][63:0]);
    end
    @(negedge clk); #2;
    check("R8 idle", acc_rdata, 64'h0);
    access(1'b0, 1'b0, 12'h004, 64'h0, "R9 ctrl hi", 64'h0);
    access(1'b0, 1'b1, 12'h10C, 64'h0, "R8 wide misaligned", 64'h040F000000000000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 1'b1, 12'h100, 64'h0, "R1 after reset", 64'h0107000000000000);
    access(1'b0, 1'b1, 12'h000, 64'h0, "R1 run bit", 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule